// File: doc/BRIEF.md
# Hierarchical bounded-delay bus arbiter

This block decides which core may use the bus that links several cores to a shared cache. Each core runs one hard real-time thread and a few non-real-time threads. Each thread raises its own request line and holds it until it sees its grant. Arbitration has two levels. Inside each core, a small arbiter always prefers the real-time thread and rotates among the non-real-time threads. Across cores, a round-robin arbiter first serves the cores that have a real-time request pending, and only then serves cores that have non-real-time work alone. A grant starts a transfer that holds the bus for a fixed number of cycles and cannot be cut short. The next transfer can be granted in the cycle after the last busy cycle.

Because no core can win twice while a real-time request waits, a real-time request has a fixed worst-case wait. In the worst case, the core's own non-real-time transfer has only just started, and every other core then takes one transfer. The bound is therefore cores × transfer length cycles, with the request's first cycle counted as cycle zero. The worst-case mode is for timing measurement. In this mode a real-time transfer still uses the bus as soon as it wins, but the grant to the thread is held back until the bound is reached. Every real-time access then takes exactly the analysed wait.

Top module: `hbus_arb`

## Requirements
- R1: While rst_ni is low, every grant output and busy_o are 0.
- R2: With the bus idle and no other request, a request that is raised in cycle c is granted in cycle c+1 (wait 1), for both real-time and non-real-time lines.
- R3: When a core's real-time request and its non-real-time requests are pending at the same arbitration point, the real-time thread is granted first.
- R4: After core s is granted, the next grants go to the requesting cores in the order s+1, s+2, … modulo NUM_CORES. The same order applies when all cores request at once.
- R5: A core that has a real-time request pending is chosen before any core that has only non-real-time requests, whatever the round-robin position.
- R6: busy_o is 1 for exactly XFER_LEN cycles, starting in the grant cycle. Two grants are at least XFER_LEN cycles apart, and a waiting request is granted directly after the last busy cycle.
- R7: Outside worst-case mode, at most one grant is high in any cycle. A grant only goes to a line that is requesting.
- R8: Outside worst-case mode, no real-time request waits more than WAIT_BOUND = NUM_CORES × XFER_LEN cycles. This wait is reached exactly when a core's own non-real-time transfer has just started and all other cores request.
- R9: With wcet_mode_i high, every real-time grant comes exactly WAIT_BOUND cycles after the request was first raised, whatever the contention. Non-real-time lines keep their normal timing, so an idle-bus wait is still 1.
- R10: Within a core, non-real-time thread t sits on bit c × NUM_NRT + t. These threads are served round robin, with the search starting just after the thread that was granted last, and thread 0 first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wcet_mode_i | input | 1 | Worst-case mode: real-time grants are held to the full bound |
| hrt_req_i | input | NUM_CORES | Real-time request, one per core, held until granted |
| nrt_req_i | input | NUM_CORES*NUM_NRT | Non-real-time requests, bit c*NUM_NRT+t for thread t of core c |
| hrt_gnt_o | output | NUM_CORES | One-cycle grant pulse per real-time thread |
| nrt_gnt_o | output | NUM_CORES*NUM_NRT | One-cycle grant pulse per non-real-time thread |
| busy_o | output | 1 | Bus occupied by a transfer |

## Verification
The hardest case to reach is the exact worst-case wait. It needs a core's own non-real-time transfer to be granted in the very cycle that every real-time line rises. The round-robin pointer then sits just past that core, and all other cores come before it. The bench raises one non-real-time line, steps one cycle and raises all real-time lines. It repeats this for each core, in both normal and worst-case mode. The round-robin and priority sweeps first set the pointer with a single grant to a chosen core, so every later grant order follows from the requirements alone.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // bid a core presents to the intercore level
  typedef struct packed {
    logic any;
    logic hrt;
  } core_bid_t;
endpackage

// File: rtl/hbus_rr_pick.sv
module hbus_rr_pick #(
  parameter  int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    logic [IW-1:0] j;
    any_o = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int unsigned k = 0; k < N; k++) begin
      j = IW'((32'(ptr_i) + k) % N);
      if (!any_o && req_i[j]) begin
        any_o    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = j;
      end
    end
  end
endmodule

// File: rtl/hbus_core_arb.sv
module hbus_core_arb import hbus_pkg::*; #(
  parameter int unsigned NUM_NRT    = 3,
  parameter int unsigned WAIT_BOUND = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wcet_mode_i,
  input  logic               hrt_req_i,
  input  logic [NUM_NRT-1:0] nrt_req_i,
  input  logic               win_i,
  output core_bid_t          bid_o,
  output logic               hrt_gnt_o,
  output logic [NUM_NRT-1:0] nrt_gnt_o
);
  localparam int unsigned CW  = $clog2(WAIT_BOUND + 1);
  localparam int unsigned NIW = (NUM_NRT > 1) ? $clog2(NUM_NRT) : 1;

  logic               hrt_gnt_q;
  logic [NUM_NRT-1:0] nrt_gnt_q;
  logic               held_q;
  logic [CW-1:0]      wait_q;
  logic [NIW-1:0]     nptr_q;

  logic               hrt_elig;
  logic [NUM_NRT-1:0] nrt_elig;
  logic               nrt_any;
  logic [NUM_NRT-1:0] nrt_pick;
  logic [NIW-1:0]     nrt_idx;
  logic               at_bound;
  logic               take_hrt;
  logic               take_nrt;
  logic               release_held;

  // a line in its grant cycle is not re-arbitrated
  assign hrt_elig = hrt_req_i & ~hrt_gnt_q & ~held_q;
  assign nrt_elig = nrt_req_i & ~nrt_gnt_q;

  hbus_rr_pick #(.N(NUM_NRT)) u_nrt_rr (
    .req_i (nrt_elig),
    .ptr_i (nptr_q),
    .any_o (nrt_any),
    .gnt_o (nrt_pick),
    .idx_o (nrt_idx)
  );

  assign bid_o.hrt    = hrt_elig;
  assign bid_o.any    = hrt_elig | nrt_any;
  assign at_bound     = (wait_q == CW'(WAIT_BOUND - 1));
  assign take_hrt     = win_i & hrt_elig;
  assign take_nrt     = win_i & ~hrt_elig & nrt_any;
  assign release_held = held_q & at_bound;

  assign hrt_gnt_o = hrt_gnt_q;
  assign nrt_gnt_o = nrt_gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hrt_gnt_q <= 1'b0;
      nrt_gnt_q <= '0;
      held_q    <= 1'b0;
      wait_q    <= '0;
      nptr_q    <= '0;
    end else begin
      hrt_gnt_q <= (take_hrt & (~wcet_mode_i | at_bound)) | release_held;
      nrt_gnt_q <= take_nrt ? nrt_pick : '0;

      // worst-case mode: slot used now, thread released at the bound
      if (release_held)
        held_q <= 1'b0;
      else if (take_hrt & wcet_mode_i & ~at_bound)
        held_q <= 1'b1;

      if (hrt_req_i & ~hrt_gnt_q) begin
        if (wait_q != CW'(WAIT_BOUND)) wait_q <= wait_q + 1'b1;
      end else begin
        wait_q <= '0;
      end

      if (take_nrt)
        nptr_q <= (nrt_idx == NIW'(NUM_NRT - 1)) ? '0 : nrt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/hbus_core_sel.sv
module hbus_core_sel import hbus_pkg::*; #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned XFER_LEN  = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  core_bid_t [NUM_CORES-1:0]   bid_i,
  output logic      [NUM_CORES-1:0]   win_o,
  output logic                        busy_o
);
  localparam int unsigned IW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int unsigned CNTW = $clog2(XFER_LEN + 1);

  logic [NUM_CORES-1:0] any_v;
  logic [NUM_CORES-1:0] hrt_v;
  logic [NUM_CORES-1:0] cand;
  logic                 pick_any;
  logic [NUM_CORES-1:0] pick_oh;
  logic [IW-1:0]        pick_idx;
  logic [IW-1:0]        ptr_q;
  logic [CNTW-1:0]      cnt_q;
  logic                 free;
  logic                 issue;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bid
    assign any_v[c] = bid_i[c].any;
    assign hrt_v[c] = bid_i[c].hrt;
  end

  // real-time class first, then everyone
  assign cand = (|hrt_v) ? hrt_v : any_v;

  hbus_rr_pick #(.N(NUM_CORES)) u_core_rr (
    .req_i (cand),
    .ptr_i (ptr_q),
    .any_o (pick_any),
    .gnt_o (pick_oh),
    .idx_o (pick_idx)
  );

  // decide in the last busy cycle so transfers run back to back
  assign free   = (cnt_q <= CNTW'(1));
  assign issue  = free & pick_any;
  assign win_o  = issue ? pick_oh : '0;
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (issue) begin
      cnt_q <= CNTW'(XFER_LEN);
      ptr_q <= (pick_idx == IW'(NUM_CORES - 1)) ? '0 : pick_idx + 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hbus_arb.sv
module hbus_arb import hbus_pkg::*; #(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_NRT    = 3,
  parameter int unsigned XFER_LEN   = 5,
  parameter int unsigned WAIT_BOUND = NUM_CORES * XFER_LEN
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wcet_mode_i,
  input  logic [NUM_CORES-1:0]           hrt_req_i,
  input  logic [NUM_CORES*NUM_NRT-1:0]   nrt_req_i,
  output logic [NUM_CORES-1:0]           hrt_gnt_o,
  output logic [NUM_CORES*NUM_NRT-1:0]   nrt_gnt_o,
  output logic                           busy_o
);
  core_bid_t [NUM_CORES-1:0] bid;
  logic      [NUM_CORES-1:0] win;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    hbus_core_arb #(
      .NUM_NRT    (NUM_NRT),
      .WAIT_BOUND (WAIT_BOUND)
    ) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wcet_mode_i (wcet_mode_i),
      .hrt_req_i   (hrt_req_i[c]),
      .nrt_req_i   (nrt_req_i[c*NUM_NRT +: NUM_NRT]),
      .win_i       (win[c]),
      .bid_o       (bid[c]),
      .hrt_gnt_o   (hrt_gnt_o[c]),
      .nrt_gnt_o   (nrt_gnt_o[c*NUM_NRT +: NUM_NRT])
    );
  end

  hbus_core_sel #(
    .NUM_CORES (NUM_CORES),
    .XFER_LEN  (XFER_LEN)
  ) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bid_i  (bid),
    .win_o  (win),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/hbus_arb_chk.sv
module hbus_arb_chk #(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_NRT    = 3,
  parameter int unsigned XFER_LEN   = 5,
  parameter int unsigned WAIT_BOUND = NUM_CORES * XFER_LEN
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wcet_mode_i,
  input logic [NUM_CORES-1:0]         hrt_req_i,
  input logic [NUM_CORES*NUM_NRT-1:0] nrt_req_i,
  input logic [NUM_CORES-1:0]         hrt_gnt_o,
  input logic [NUM_CORES*NUM_NRT-1:0] nrt_gnt_o,
  input logic                         busy_o
);
  localparam int unsigned CW = $clog2(WAIT_BOUND + 2);
  localparam int unsigned GW = $clog2(XFER_LEN + 1);

  logic          start;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] w_q [NUM_CORES];

  assign start = (|hrt_gnt_o) | (|nrt_gnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      for (int c = 0; c < NUM_CORES; c++) w_q[c] <= '0;
    end else begin
      if (start) gap_q <= GW'(XFER_LEN - 1);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (hrt_req_i[c] && !hrt_gnt_o[c]) begin
          if (w_q[c] != CW'(WAIT_BOUND + 1)) w_q[c] <= w_q[c] + 1'b1;
        end else begin
          w_q[c] <= '0;
        end
      end
    end
  end

  // R7
  a_r7_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wcet_mode_i |-> $onehot0({hrt_gnt_o, nrt_gnt_o}));

  a_r7_grant_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hrt_gnt_o & ~hrt_req_i) == '0) && ((nrt_gnt_o & ~nrt_req_i) == '0));

  // R6
  a_r6_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wcet_mode_i |-> (busy_o == (start || gap_q != '0)));

  a_r6_grant_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wcet_mode_i && start) |-> (gap_q == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    // R8
    a_r8_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wcet_mode_i && hrt_req_i[c]) |-> (w_q[c] <= CW'(WAIT_BOUND)));

    // R9
    a_r9_exact_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wcet_mode_i && hrt_gnt_o[c]) |-> (w_q[c] == CW'(WAIT_BOUND)));

    // R3
    a_r3_hrt_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wcet_mode_i && (|nrt_gnt_o[c*NUM_NRT +: NUM_NRT]))
        |-> !$past(hrt_req_i[c] && !hrt_gnt_o[c]));
  end
endmodule

bind hbus_arb hbus_arb_chk #(
  .NUM_CORES  (NUM_CORES),
  .NUM_NRT    (NUM_NRT),
  .XFER_LEN   (XFER_LEN),
  .WAIT_BOUND (WAIT_BOUND)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wcet_mode_i (wcet_mode_i),
  .hrt_req_i   (hrt_req_i),
  .nrt_req_i   (nrt_req_i),
  .hrt_gnt_o   (hrt_gnt_o),
  .nrt_gnt_o   (nrt_gnt_o),
  .busy_o      (busy_o)
);

// File: tb/hbus_arb_tb.sv
module hbus_arb_tb;
  localparam int NC = 4;
  localparam int NN = 3;
  localparam int L  = 5;
  localparam int B  = NC * L;

  logic clk = 1'b0;
  logic rst_n;
  logic wcet;
  logic [NC-1:0]    hreq;
  logic [NC*NN-1:0] nreq;
  logic [NC-1:0]    hgnt;
  logic [NC*NN-1:0] ngnt;
  logic             busy;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int hr_c [NC];
  int hg_c [NC];
  int nr_c [NC*NN];
  int ng_c [NC*NN];
  int log_code [64];
  int n_log;
  int busy_cnt;
  logic [NC-1:0]    h_raise;
  logic [NC*NN-1:0] n_raise;
  logic             wcet_nx;

  hbus_arb #(.NUM_CORES(NC), .NUM_NRT(NN), .XFER_LEN(L)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wcet_mode_i (wcet),
    .hrt_req_i   (hreq),
    .nrt_req_i   (nreq),
    .hrt_gnt_o   (hgnt),
    .nrt_gnt_o   (ngnt),
    .busy_o      (busy)
  );

  initial forever #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [NC-1:0]    hs;
    logic [NC*NN-1:0] ns;
    @(negedge clk);
    hs = hgnt;
    ns = ngnt;
    if (busy) busy_cnt++;
    if ((hs | ns) != 0) begin
      check("R7 grant only to requester", int'(((hs & ~hreq) != 0) || ((ns & ~nreq) != 0)), 0);
      if (!wcet) check("R7 one grant per cycle", $countones({hs, ns}), 1);
    end
    for (int i = 0; i < NC; i++) if (hs[i]) begin
      hg_c[i] = cyc;
      if (n_log < 64) begin log_code[n_log] = i; n_log++; end
    end
    for (int j = 0; j < NC*NN; j++) if (ns[j]) begin
      ng_c[j] = cyc;
      if (n_log < 64) begin log_code[n_log] = 100 + j; n_log++; end
    end
    @(posedge clk);
    #1;
    hreq = hreq & ~hs;
    nreq = nreq & ~ns;
    wcet = wcet_nx;
    for (int i = 0; i < NC; i++) if (h_raise[i]) begin hreq[i] = 1'b1; hr_c[i] = cyc; end
    for (int j = 0; j < NC*NN; j++) if (n_raise[j]) begin nreq[j] = 1'b1; nr_c[j] = cyc; end
    h_raise = '0;
    n_raise = '0;
  endtask

  task automatic run_idle();
    int n;
    n = 0;
    while ((hreq != 0 || nreq != 0 || h_raise != 0 || n_raise != 0) && n < 400) begin
      step();
      n++;
    end
    if (n >= 400) check("watchdog request never granted", 1, 0);
    repeat (L + 2) step();
  endtask

  task automatic solo_hrt(input int s);
    h_raise[s] = 1'b1;
    run_idle();
  endtask

  initial begin
    rst_n = 1'b0; wcet = 1'b0; wcet_nx = 1'b0;
    hreq = '0; nreq = '0; h_raise = '0; n_raise = '0;
    n_log = 0; busy_cnt = 0;
    for (int i = 0; i < NC; i++) begin hr_c[i] = 0; hg_c[i] = -1; end
    for (int j = 0; j < NC*NN; j++) begin nr_c[j] = 0; ng_c[j] = -1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset hrt grants", int'(hgnt), 0);
    check("R1 reset nrt grants", int'(ngnt), 0);
    check("R1 reset busy", int'(busy), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) step();

    // R2 / R6: lone requests on an idle bus
    for (int i = 0; i < NC; i++) begin
      busy_cnt = 0;
      solo_hrt(i);
      check($sformatf("R2 hrt core %0d idle wait", i), hg_c[i] - hr_c[i], 1);
      check($sformatf("R6 busy length core %0d", i), busy_cnt, L);
    end
    for (int j = 0; j < NC*NN; j++) begin
      n_raise[j] = 1'b1;
      run_idle();
      check($sformatf("R2 nrt line %0d idle wait", j), ng_c[j] - nr_c[j], 1);
    end

    // R3: real-time before own non-real-time; nrt pointer at 0 here
    for (int k = 0; k < NC; k++) begin
      n_log = 0;
      h_raise[k] = 1'b1;
      for (int t = 0; t < NN; t++) n_raise[k*NN+t] = 1'b1;
      run_idle();
      check($sformatf("R3 core %0d first grant", k), log_code[0], k);
      check($sformatf("R3 core %0d hrt wait", k), hg_c[k] - hr_c[k], 1);
      for (int t = 0; t < NN; t++)
        check($sformatf("R10 core %0d slot %0d", k, t + 1), log_code[t+1], 100 + k*NN + t);
      check($sformatf("R6 core %0d back-to-back spacing", k), ng_c[k*NN+NN-1] - nr_c[k*NN+NN-1], 1 + NN*L);
    end

    // R10: rotation starts after the last granted thread
    for (int k = 0; k < NC; k++) begin
      n_raise[k*NN+1] = 1'b1;
      run_idle();
      n_log = 0;
      for (int t = 0; t < NN; t++) n_raise[k*NN+t] = 1'b1;
      run_idle();
      for (int t = 0; t < NN; t++)
        check($sformatf("R10 core %0d rotated slot %0d", k, t), log_code[t], 100 + k*NN + ((t + 2) % NN));
    end

    // R4 / R6: all cores at once after a known pointer
    for (int s = 0; s < NC; s++) begin
      solo_hrt(s);
      n_log = 0;
      h_raise = '1;
      run_idle();
      for (int j = 0; j < NC; j++) begin
        check($sformatf("R4 after core %0d order %0d", s, j), log_code[j], (s + 1 + j) % NC);
        check($sformatf("R6 after core %0d wait %0d", s, j), hg_c[(s+1+j)%NC] - hr_c[(s+1+j)%NC], 1 + j*L);
      end
    end

    // R5: real-time core beats earlier round-robin non-real-time core
    for (int s = 0; s < NC; s++) begin
      solo_hrt(s);
      n_log = 0;
      n_raise[((s + 1) % NC)*NN] = 1'b1;
      h_raise[(s + 2) % NC] = 1'b1;
      run_idle();
      check($sformatf("R5 after core %0d first", s), log_code[0], (s + 2) % NC);
      check($sformatf("R5 after core %0d second", s), log_code[1], 100 + ((s + 1) % NC)*NN);
    end

    // R8: own non-real-time transfer in flight plus full contention
    for (int k = 0; k < NC; k++) begin
      n_raise[k*NN] = 1'b1;
      step();
      h_raise = '1;
      step();
      run_idle();
      check($sformatf("R8 core %0d worst wait", k), hg_c[k] - hr_c[k], B);
      for (int j = 0; j < NC - 1; j++)
        check($sformatf("R8 core %0d other %0d wait", k, j), hg_c[(k+1+j)%NC] - hr_c[(k+1+j)%NC], (j + 1)*L);
    end

    // R9: worst-case mode
    wcet_nx = 1'b1;
    step();
    for (int k = 0; k < NC; k++) begin
      solo_hrt(k);
      check($sformatf("R9 solo core %0d wait", k), hg_c[k] - hr_c[k], B);
    end
    h_raise = '1;
    run_idle();
    for (int k = 0; k < NC; k++)
      check($sformatf("R9 contended core %0d wait", k), hg_c[k] - hr_c[k], B);
    for (int k = 0; k < NC; k++) begin
      n_raise[k*NN] = 1'b1;
      step();
      h_raise = '1;
      step();
      run_idle();
      check($sformatf("R9 nrt core %0d idle wait", k), ng_c[k*NN] - nr_c[k*NN], 1);
      for (int j = 0; j < NC; j++)
        check($sformatf("R9 in-flight core %0d line %0d wait", k, j), hg_c[j] - hr_c[j], B);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule